// File: doc/BRIEF.md
# E1 Receive Line Alarm Monitor

This block sits behind the receive framer of a 2.048 Mb/s E1 line and watches the recovered bit stream. It has no clock of its own. A bit-enable strobe marks each received bit. From that stream it keeps four level alarms:

- unframed all-ones, the alarm indication signal;
- all-ones in timeslot 16;
- a sustained alternating 1010 auxiliary pattern;
- loss of signal.

For each level it also gives a one-cycle change pulse. A downstream interrupt controller uses the pulses. The framer supplies a flag that is high while timeslot-16 bits are being received. A static configuration input picks the length of the all-ones window.

Loss of signal is entered on a long run of zeros. It is left only through a separate ones-density test. That test runs over a window that always opens on a received one. The asymmetric rule gives hysteresis, so a marginal line does not make the alarm chatter. All internal state is cleared by an asynchronous active-low reset. The reset is released to the logic through a two-stage synchronizer.

Top module: `e1_rx_alarm_mon`

## Requirements
- R1: With `ais_win_long`=0, `ais_alarm` rises one clock after the 512th consecutive one is strobed. Any strobed zero lowers it one clock after that zero.
- R2: With `ais_win_long`=1, `ais_alarm` needs 1024 consecutive strobed ones. The window length is re-evaluated on every strobed bit, using the current run of ones.
- R3: `aux_alarm` is high from the clock after the 512th bit of an unbroken alternating run, where every bit differs from the previous one. Two equal bits in a row restart the run at length 1. After reset, the first bit counts as a run of length 1.
- R4: `slot16_alarm` is updated once per pass through timeslot 16. The update happens on the clock after the 8th strobed bit taken with `slot16_flag`=1. The new value is 1 only if all 8 of those bits were ones.
- R5: Outside loss of signal, `los_alarm` rises one clock after the 256th consecutive strobed zero. A strobed one resets the zero run.
- R6: During loss of signal, a measurement window spans 255 strobed bit positions. The alarm falls one clock after the last position of a window holding at least 32 ones. A window with fewer ones is discarded.
- R7: A clearing window opens only on a strobed one, which is position 1. Zeros received while no window is open are ignored.
- R8: Each alarm has a change output. It is high for exactly the first clock in which that alarm shows a new value, on both rising and falling transitions.
- R9: Clocks with `bit_en`=0 leave all alarm state unchanged, whatever `rx_bit` and `slot16_flag` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Strobe marking a valid received bit |
| rx_bit | input | 1 | Received data bit |
| slot16_flag | input | 1 | High while the strobed bit belongs to timeslot 16 |
| ais_win_long | input | 1 | 0: 512-bit all-ones window, 1: 1024-bit window |
| ais_alarm | output | 1 | Unframed all-ones alarm level |
| slot16_alarm | output | 1 | Timeslot-16 all-ones alarm level |
| aux_alarm | output | 1 | Alternating-pattern alarm level |
| los_alarm | output | 1 | Loss-of-signal alarm level |
| ais_chg | output | 1 | One-cycle pulse when `ais_alarm` changes |
| slot16_chg | output | 1 | One-cycle pulse when `slot16_alarm` changes |
| aux_chg | output | 1 | One-cycle pulse when `aux_alarm` changes |
| los_chg | output | 1 | One-cycle pulse when `los_alarm` changes |

## Verification
Long all-ones runs under both window settings, including a switch of the setting mid-run, separate the two AIS thresholds. A single zero near the end of a run shows that the count restarts rather than pauses. Alternating runs broken by a doubled bit check the auxiliary restart to length one. Framed traffic with timeslot 16 forced to all ones, or carrying one zero, separates the per-slot decision from the bits around it. For loss of signal, a zero run is followed by sparse ones below the 32-in-255 density and then by denser ones, which tells the entry rule apart from the exit rule. Strobed and unstrobed clocks are interleaved, with `rx_bit` flipping on the idle clocks, to show that only strobed bits count.

// File: rtl/lam_pkg.sv
`timescale 1ns/1ps
package lam_pkg;
  localparam int unsigned N_ALARMS = 4;

  typedef enum logic [1:0] {
    AL_AIS  = 2'd0,
    AL_S16  = 2'd1,
    AL_AUX  = 2'd2,
    AL_LOS  = 2'd3
  } alarm_idx_e;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/lam_rst_sync.sv
`timescale 1ns/1ps
module lam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/lam_run_det.sv
`timescale 1ns/1ps
// Saturating run-length counter with a programmable threshold.
module lam_run_det #(
  parameter int unsigned CAP         = 1024,
  parameter bit          RESTART_ONE = 1'b0,
  parameter int unsigned W           = lam_pkg::cnt_w(CAP)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         match_i,
  input  logic [W-1:0] thresh_i,
  output logic         alarm_o
);
  localparam logic [W-1:0] CAP_V   = W'(CAP);
  localparam logic [W-1:0] RESTART = RESTART_ONE ? W'(1) : W'(0);

  logic [W-1:0] run_q, run_d;
  logic         alarm_q, alarm_d;

  always_comb begin
    run_d   = run_q;
    alarm_d = alarm_q;
    if (bit_en) begin
      if (match_i) begin
        run_d = (run_q == CAP_V) ? run_q : run_q + W'(1);
      end else begin
        run_d = RESTART;
      end
      alarm_d = (run_d >= thresh_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm_o = alarm_q;

  p_run_capped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CAP_V);

  // R1 and R3: a broken run drops the alarm on the next clock
  p_break_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !match_i && thresh_i > RESTART) |=> !alarm_o);
endmodule

// File: rtl/lam_slot_chk.sv
`timescale 1ns/1ps
module lam_slot_chk #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned CW        = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic slot_i,
  input  logic rx_bit,
  output logic alarm_o
);
  localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_q, acc_d;
  logic          alarm_q, alarm_d;

  always_comb begin
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    alarm_d = alarm_q;
    if (bit_en && slot_i) begin
      acc_d = ((cnt_q == '0) ? 1'b1 : acc_q) & rx_bit;
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        alarm_d = acc_d;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm_o = alarm_q;

  p_slot_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarm_o) |-> $past(bit_en && slot_i && cnt_q == LAST));

  p_zero_in_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_i && !rx_bit && cnt_q == LAST) |=> !alarm_o);
endmodule

// File: rtl/lam_los_det.sv
`timescale 1ns/1ps
module lam_los_det #(
  parameter int unsigned ZERO_LIMIT = 255,
  parameter int unsigned WIN_LEN    = 255,
  parameter int unsigned MIN_ONES   = 32,
  parameter int unsigned ZW         = lam_pkg::cnt_w(ZERO_LIMIT + 1),
  parameter int unsigned PW         = lam_pkg::cnt_w(WIN_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic los_o
);
  localparam logic [ZW-1:0] ZCAP  = ZW'(ZERO_LIMIT + 1);
  localparam logic [PW-1:0] WEND  = PW'(WIN_LEN);
  localparam logic [PW-1:0] OMIN  = PW'(MIN_ONES);

  logic          los_q, los_d;
  logic [ZW-1:0] zrun_q, zrun_d;
  logic          act_q, act_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [PW-1:0] ones_q, ones_d;

  always_comb begin
    los_d  = los_q;
    zrun_d = zrun_q;
    act_d  = act_q;
    pos_d  = pos_q;
    ones_d = ones_q;
    if (bit_en) begin
      if (!los_q) begin
        if (rx_bit) begin
          zrun_d = '0;
        end else if (zrun_q != ZCAP) begin
          zrun_d = zrun_q + ZW'(1);
        end
        if (zrun_d == ZCAP) begin
          los_d = 1'b1;
          act_d = 1'b0;
        end
      end else if (!act_q) begin
        if (rx_bit) begin
          act_d  = 1'b1;
          pos_d  = PW'(1);
          ones_d = PW'(1);
        end
      end else begin
        pos_d  = pos_q + PW'(1);
        ones_d = ones_q + PW'(rx_bit);
        if (pos_d == WEND) begin
          act_d = 1'b0;
          if (ones_d >= OMIN) begin
            los_d  = 1'b0;
            zrun_d = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q  <= 1'b0;
      zrun_q <= '0;
      act_q  <= 1'b0;
      pos_q  <= '0;
      ones_q <= '0;
    end else begin
      los_q  <= los_d;
      zrun_q <= zrun_d;
      act_q  <= act_d;
      pos_q  <= pos_d;
      ones_q <= ones_d;
    end
  end

  assign los_o = los_q;

  p_los_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_o) |-> $past(bit_en && !rx_bit));

  p_los_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_o) |-> $past(bit_en && act_q && pos_q == WEND - PW'(1)));

  p_win_opens_on_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(bit_en && rx_bit && los_q));

  p_pos_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (pos_q < WEND));
endmodule

// File: rtl/e1_rx_alarm_mon.sv
`timescale 1ns/1ps
module e1_rx_alarm_mon #(
  parameter int unsigned AIS_SHORT  = 512,
  parameter int unsigned AIS_LONG   = 1024,
  parameter int unsigned AUX_LEN    = 512,
  parameter int unsigned SLOT_BITS  = 8,
  parameter int unsigned LOS_ZEROS  = 255,
  parameter int unsigned LOS_WIN    = 255,
  parameter int unsigned LOS_ONES   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic slot16_flag,
  input  logic ais_win_long,
  output logic ais_alarm,
  output logic slot16_alarm,
  output logic aux_alarm,
  output logic los_alarm,
  output logic ais_chg,
  output logic slot16_chg,
  output logic aux_chg,
  output logic los_chg
);
  import lam_pkg::*;

  localparam int unsigned AIS_W = cnt_w(AIS_LONG);
  localparam int unsigned AUX_W = cnt_w(AUX_LEN);

  logic srst_n;
  logic prev_bit_q, prev_ok_q;
  logic aux_match;
  logic [AIS_W-1:0] ais_thresh;
  logic [N_ALARMS-1:0] alarm_vec, alarm_d_q, chg_vec;

  lam_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // previous strobed bit for the alternation test
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prev_bit_q <= 1'b0;
      prev_ok_q  <= 1'b0;
    end else if (bit_en) begin
      prev_bit_q <= rx_bit;
      prev_ok_q  <= 1'b1;
    end
  end

  assign aux_match  = prev_ok_q && (rx_bit != prev_bit_q);
  assign ais_thresh = ais_win_long ? AIS_W'(AIS_LONG) : AIS_W'(AIS_SHORT);

  lam_run_det #(.CAP(AIS_LONG), .RESTART_ONE(1'b0)) u_ais (
    .clk      (clk),
    .rst_n    (srst_n),
    .bit_en   (bit_en),
    .match_i  (rx_bit),
    .thresh_i (ais_thresh),
    .alarm_o  (alarm_vec[AL_AIS])
  );

  lam_run_det #(.CAP(AUX_LEN), .RESTART_ONE(1'b1)) u_aux (
    .clk      (clk),
    .rst_n    (srst_n),
    .bit_en   (bit_en),
    .match_i  (aux_match),
    .thresh_i (AUX_W'(AUX_LEN)),
    .alarm_o  (alarm_vec[AL_AUX])
  );

  lam_slot_chk #(.SLOT_BITS(SLOT_BITS)) u_s16 (
    .clk     (clk),
    .rst_n   (srst_n),
    .bit_en  (bit_en),
    .slot_i  (slot16_flag),
    .rx_bit  (rx_bit),
    .alarm_o (alarm_vec[AL_S16])
  );

  lam_los_det #(.ZERO_LIMIT(LOS_ZEROS), .WIN_LEN(LOS_WIN), .MIN_ONES(LOS_ONES)) u_los (
    .clk    (clk),
    .rst_n  (srst_n),
    .bit_en (bit_en),
    .rx_bit (rx_bit),
    .los_o  (alarm_vec[AL_LOS])
  );

  for (genvar g = 0; g < N_ALARMS; g++) begin : g_chg
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) alarm_d_q[g] <= 1'b0;
      else         alarm_d_q[g] <= alarm_vec[g];
    end
    assign chg_vec[g] = alarm_vec[g] ^ alarm_d_q[g];
  end

  assign ais_alarm    = alarm_vec[AL_AIS];
  assign slot16_alarm = alarm_vec[AL_S16];
  assign aux_alarm    = alarm_vec[AL_AUX];
  assign los_alarm    = alarm_vec[AL_LOS];
  assign ais_chg      = chg_vec[AL_AIS];
  assign slot16_chg   = chg_vec[AL_S16];
  assign aux_chg      = chg_vec[AL_AUX];
  assign los_chg      = chg_vec[AL_LOS];

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(bit_en) |-> $stable(alarm_vec));

  p_idle_no_pulse_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !$past(bit_en) |-> (chg_vec == '0));
endmodule

// File: tb/sim_e1_rx_alarm_mon.sv
`timescale 1ns/1ps
module sim_e1_rx_alarm_mon;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, slot16_flag = 1'b0, ais_win_long = 1'b0;
  logic ais_alarm, slot16_alarm, aux_alarm, los_alarm;
  logic ais_chg, slot16_chg, aux_chg, los_chg;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit sparse = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_rx_alarm_mon u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .slot16_flag(slot16_flag), .ais_win_long(ais_win_long),
    .ais_alarm(ais_alarm), .slot16_alarm(slot16_alarm),
    .aux_alarm(aux_alarm), .los_alarm(los_alarm),
    .ais_chg(ais_chg), .slot16_chg(slot16_chg),
    .aux_chg(aux_chg), .los_chg(los_chg)
  );

  // ---------------- behavioural reference ----------------
  int ais_run, aux_run, s_cnt, zr, pos, ones;
  bit prev_b, have_prev, s_acc, act;
  bit m_ais, m_s16, m_aux, m_los;
  bit p_ais, p_s16, p_aux, p_los;

  always @(posedge clk) begin
    if (!rst_n) begin
      ais_run = 0; aux_run = 0; s_cnt = 0; zr = 0; pos = 0; ones = 0;
      prev_b = 0; have_prev = 0; s_acc = 0; act = 0;
      m_ais = 0; m_s16 = 0; m_aux = 0; m_los = 0;
      p_ais = 0; p_s16 = 0; p_aux = 0; p_los = 0;
    end else begin
      p_ais = m_ais; p_s16 = m_s16; p_aux = m_aux; p_los = m_los;
      if (bit_en) begin   // R9: nothing moves without a strobe
        ais_run = rx_bit ? ((ais_run < 1024) ? ais_run + 1 : 1024) : 0;
        m_ais = (ais_run >= (ais_win_long ? 1024 : 512));
        aux_run = (have_prev && rx_bit != prev_b) ? ((aux_run < 512) ? aux_run + 1 : 512) : 1;
        m_aux = (aux_run >= 512);
        prev_b = rx_bit; have_prev = 1;
        if (slot16_flag) begin
          if (s_cnt == 0) s_acc = 1;
          s_acc = s_acc & rx_bit;
          if (s_cnt == 7) m_s16 = s_acc;
          s_cnt = (s_cnt + 1) % 8;
        end
        if (!m_los) begin
          zr = rx_bit ? 0 : ((zr < 256) ? zr + 1 : 256);
          if (zr >= 256) begin m_los = 1; act = 0; end
        end else if (!act) begin
          if (rx_bit) begin act = 1; pos = 1; ones = 1; end  // R7
        end else begin
          pos++; ones += rx_bit;
          if (pos == 255) begin
            act = 0;
            if (ones >= 32) begin m_los = 0; zr = 0; end
          end
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic act_v, input logic exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act_v, exp_v);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (!done) begin
      cmp("R1 R2 ais_alarm", ais_alarm, m_ais);
      cmp("R4 slot16_alarm", slot16_alarm, m_s16);
      cmp("R3 aux_alarm", aux_alarm, m_aux);
      cmp("R5 R6 R7 los_alarm", los_alarm, m_los);
      cmp("R8 ais_chg", ais_chg, m_ais != p_ais);
      cmp("R8 slot16_chg", slot16_chg, m_s16 != p_s16);
      cmp("R8 aux_chg", aux_chg, m_aux != p_aux);
      cmp("R8 los_chg", los_chg, m_los != p_los);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic b, input logic t);
    @(negedge clk);
    rx_bit = b; slot16_flag = t; bit_en = 1'b1;
    if (sparse) begin
      @(negedge clk);
      bit_en = 1'b0; rx_bit = ~b; slot16_flag = ~t;  // R9: idle-clock noise
    end
  endtask

  task automatic run_const(input logic b, input int n);
    for (int i = 0; i < n; i++) send(b, 1'b0);
  endtask

  task automatic run_alt(input int n);
    for (int i = 0; i < n; i++) send(i[0], 1'b0);
  endtask

  task automatic frames(input int n, input bit s16_ones, input int bad_pos);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < 256; i++) begin
        if (i >= 128 && i < 136)
          send((s16_ones && (i - 128) != bad_pos) ? 1'b1 : 1'b0, 1'b1);
        else
          send(1'($urandom_range(0, 1)), 1'b0);
      end
  endtask

  task automatic run_density(input int period, input int n);
    for (int i = 0; i < n; i++) send((i % period) == 0, 1'b0);
  endtask

  initial begin
    void'($urandom(7));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);   // reset state compared each clock
    // R1: 512-bit window, hit exactly and broken one short
    run_const(1'b1, 511); run_const(1'b0, 1);
    run_const(1'b1, 600); run_const(1'b0, 3);
    // R2: 1024-bit window, then shrink the window mid-run
    ais_win_long = 1'b1;
    run_const(1'b1, 1030); run_const(1'b0, 1);
    run_const(1'b1, 700);
    ais_win_long = 1'b0;
    run_const(1'b1, 2); run_const(1'b0, 1);
    // R3: alternation, a doubled bit, then full run
    sparse = 1'b0;
    run_alt(500); send(1'b0, 1'b0); send(1'b0, 1'b0);
    run_alt(520); send(1'b1, 1'b1); send(1'b1, 1'b0);
    // R4: framed traffic with timeslot 16 patterns
    sparse = 1'b1;
    frames(2, 1'b1, -1);
    frames(1, 1'b1, 7);
    frames(1, 1'b1, 0);
    frames(1, 1'b1, -1);
    frames(1, 1'b0, -1);
    // R5: exactly 255 zeros, then 256
    run_const(1'b1, 2); run_const(1'b0, 255); run_const(1'b1, 1);
    run_const(1'b0, 260);
    // R7: zeros before the first one are ignored
    run_const(1'b0, 40);
    // R6: density below 32 per 255 keeps the alarm, then enough clears it
    run_density(9, 600);
    sparse = 1'b0;
    run_density(4, 300);
    // mixed traffic
    for (int i = 0; i < 2000; i++) send(1'($urandom_range(0, 1)), (i % 64) < 8);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule